// File: doc/BRIEF.md
# Accumulator ALU with Flag Updates

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator datapath. It takes the accumulator, a second operand byte, the current carry and auxiliary-carry flags, and a 5-bit operation code. From these it produces the next accumulator value and new values for the sign, zero, auxiliary-carry, parity and carry flags. Each result has its own write-enable, so the surrounding register file updates only what the operation defines.

The operations are:

- binary add and subtract, with and without the incoming carry or borrow;
- a compare that writes flags only;
- the three bitwise operations;
- four rotates, two of them through carry;
- accumulator complement;
- carry complement and carry set;
- a decimal adjust that corrects a packed-BCD sum using the auxiliary carry.

A separate 16-bit adder serves the register-pair add, which changes the carry flag and nothing else. Operand selection and register writeback belong to the caller.

Top module: `acc_alu_flags`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, CMP=4, AND=5, XOR=6, OR=7, RLC=8, RRC=9, RAL=10, RAR=11, CMA=12, CMC=13, STC=14, DAA=15 and DAD=16. For each code the write-enables take exactly the pattern given in the requirements below.
- R2: ADD and ADC give acc+opnd (ADC adds cy_i as well) modulo 256. Carry is the bit-8 carry-out and auxiliary carry is the carry out of bit 3. All five flags and the accumulator are written.
- R3: SUB and SBB give acc-opnd (SBB also subtracts cy_i) modulo 256. Carry is set on a borrow out of bit 7 and auxiliary carry on a borrow out of the low nibble. All five flags and the accumulator are written.
- R4: CMP writes all five flags, computed as SUB would, but never the accumulator, and acc_o equals acc_i. Carry is set when acc<opnd, zero is set when they are equal, and both are clear when acc>opnd.
- R5: Whenever S, Z and P are written, S is bit 7 of the result, Z is 1 for a zero result and P is 1 when the result has an even count of ones.
- R6: AND, XOR and OR write the bitwise result and all five flags. Carry is cleared. Auxiliary carry is set by AND and cleared by XOR and OR.
- R7: RLC gives {acc[6:0],acc[7]} with carry=acc[7]. RRC gives {acc[0],acc[7:1]} with carry=acc[0].
- R8: RAL gives {acc[6:0],cy_i} with carry=acc[7]. RAR gives {cy_i,acc[7:1]} with carry=acc[0].
- R9: The four rotates write the accumulator and the carry only. CMA writes ~acc and no flag.
- R10: CMC writes carry=~cy_i and STC writes carry=1. Neither writes the accumulator or any other flag.
- R11: DAA first adds 6 when acc[3:0]>9 or ac_i is set. It then adds 0x60 when the intermediate high nibble is above 9, when cy_i is set, or when the first step carried out of bit 7. Carry becomes 1 exactly when that second correction applies. Auxiliary carry is the carry out of bit 3 from the first step. All five flags are written.
- R12: DAD drives pair_o=pair_a_i+pair_b_i modulo 65536 and raises pair_we_o. Carry is set on a carry out of bit 15. Only carry is written, and the accumulator is not.
- R13: Codes 17 to 31 raise no write-enable, and acc_o equals acc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| pair_a_i | input | 16 | Destination register pair for DAD |
| pair_b_i | input | 16 | Source register pair for DAD |
| acc_o | output | 8 | Next accumulator value |
| acc_we_o | output | 1 | Accumulator write-enable |
| pair_o | output | 16 | 16-bit pair sum |
| pair_we_o | output | 1 | Pair write-enable |
| s_o | output | 1 | Sign flag value |
| z_o | output | 1 | Zero flag value |
| ac_o | output | 1 | Auxiliary-carry flag value |
| p_o | output | 1 | Parity flag value |
| cy_o | output | 1 | Carry flag value |
| s_we_o | output | 1 | Sign write-enable |
| z_we_o | output | 1 | Zero write-enable |
| ac_we_o | output | 1 | Auxiliary-carry write-enable |
| p_we_o | output | 1 | Parity write-enable |
| cy_we_o | output | 1 | Carry write-enable |

## Verification
The assertions are evaluated whenever the inputs settle. They check the following:

- CMP's ordering outcome, and that it leaves the accumulator alone;
- that the sign, zero and parity flags agree with any written accumulator;
- that logic operations clear carry;
- the write-enable patterns of the rotates, the carry-only operations, DAD and the undefined codes.

The arithmetic values themselves can only be shown by the bench's scenarios, which compare every output against an integer reference model. Those values are the sums, borrows, nibble carries, rotate bit movement and the two-step decimal correction. The scenarios include directed BCD corner cases (low-nibble overflow, forced correction from incoming flags, and a first step that wraps past 0xFF) as well as random traffic across all 32 codes.

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags (
  input  logic [4:0]  op_i,
  input  logic [7:0]  acc_i,
  input  logic [7:0]  opnd_i,
  input  logic        cy_i,
  input  logic        ac_i,
  input  logic [15:0] pair_a_i,
  input  logic [15:0] pair_b_i,
  output logic [7:0]  acc_o,
  output logic        acc_we_o,
  output logic [15:0] pair_o,
  output logic        pair_we_o,
  output logic        s_o,
  output logic        z_o,
  output logic        ac_o,
  output logic        p_o,
  output logic        cy_o,
  output logic        s_we_o,
  output logic        z_we_o,
  output logic        ac_we_o,
  output logic        p_we_o,
  output logic        cy_we_o
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11;
  localparam logic [4:0] OP_CMA = 5'd12, OP_CMC = 5'd13, OP_STC = 5'd14, OP_DAA = 5'd15;
  localparam logic [4:0] OP_DAD = 5'd16;

  logic       cin, bin;
  logic [8:0] asum, sdif, dstep;
  logic [4:0] alo, slo;
  logic       lo_fix, hi_fix;
  logic [7:0] dres, res, fsrc;
  logic [16:0] psum;
  logic       szp_we, ac_n, cy_n;

  assign cin  = (op_i == OP_ADC) & cy_i;
  assign bin  = (op_i == OP_SBB) & cy_i;
  assign asum = {1'b0, acc_i} + {1'b0, opnd_i} + {8'd0, cin};
  assign alo  = {1'b0, acc_i[3:0]} + {1'b0, opnd_i[3:0]} + {4'd0, cin};
  assign sdif = {1'b0, acc_i} - {1'b0, opnd_i} - {8'd0, bin};
  assign slo  = {1'b0, acc_i[3:0]} - {1'b0, opnd_i[3:0]} - {4'd0, bin};

  assign lo_fix = (acc_i[3:0] > 4'd9) | ac_i;
  assign dstep  = {1'b0, acc_i} + (lo_fix ? 9'd6 : 9'd0);
  assign hi_fix = (dstep[7:4] > 4'd9) | cy_i | dstep[8];
  assign dres   = dstep[7:0] + (hi_fix ? 8'h60 : 8'h00);

  assign psum = {1'b0, pair_a_i} + {1'b0, pair_b_i};

  always_comb begin
    res       = acc_i;
    fsrc      = acc_i;
    acc_we_o  = 1'b0;
    pair_we_o = 1'b0;
    szp_we    = 1'b0;
    ac_we_o   = 1'b0;
    cy_we_o   = 1'b0;
    ac_n      = ac_i;
    cy_n      = cy_i;
    case (op_i)
      OP_ADD, OP_ADC: begin
        res = asum[7:0]; fsrc = asum[7:0];
        acc_we_o = 1'b1; szp_we = 1'b1; ac_we_o = 1'b1; cy_we_o = 1'b1;
        ac_n = alo[4]; cy_n = asum[8];
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        fsrc = sdif[7:0];
        if (op_i != OP_CMP) begin
          res = sdif[7:0];
          acc_we_o = 1'b1;
        end
        szp_we = 1'b1; ac_we_o = 1'b1; cy_we_o = 1'b1;
        ac_n = slo[4]; cy_n = sdif[8];
      end
      OP_AND, OP_XOR, OP_OR: begin
        if (op_i == OP_AND)      res = acc_i & opnd_i;
        else if (op_i == OP_XOR) res = acc_i ^ opnd_i;
        else                     res = acc_i | opnd_i;
        fsrc = res;
        acc_we_o = 1'b1; szp_we = 1'b1; ac_we_o = 1'b1; cy_we_o = 1'b1;
        ac_n = (op_i == OP_AND); cy_n = 1'b0;
      end
      OP_RLC: begin res = {acc_i[6:0], acc_i[7]}; cy_n = acc_i[7]; acc_we_o = 1'b1; cy_we_o = 1'b1; end
      OP_RRC: begin res = {acc_i[0], acc_i[7:1]}; cy_n = acc_i[0]; acc_we_o = 1'b1; cy_we_o = 1'b1; end
      OP_RAL: begin res = {acc_i[6:0], cy_i};     cy_n = acc_i[7]; acc_we_o = 1'b1; cy_we_o = 1'b1; end
      OP_RAR: begin res = {cy_i, acc_i[7:1]};     cy_n = acc_i[0]; acc_we_o = 1'b1; cy_we_o = 1'b1; end
      OP_CMA: begin res = ~acc_i; acc_we_o = 1'b1; end
      OP_CMC: begin cy_n = ~cy_i; cy_we_o = 1'b1; end
      OP_STC: begin cy_n = 1'b1;  cy_we_o = 1'b1; end
      OP_DAA: begin
        res = dres; fsrc = dres;
        acc_we_o = 1'b1; szp_we = 1'b1; ac_we_o = 1'b1; cy_we_o = 1'b1;
        ac_n = acc_i[3:0] > 4'd9; cy_n = hi_fix;
      end
      OP_DAD: begin pair_we_o = 1'b1; cy_we_o = 1'b1; cy_n = psum[16]; end
      default: ;
    endcase
  end

  assign acc_o  = res;
  assign pair_o = psum[15:0];
  assign s_o    = fsrc[7];
  assign z_o    = (fsrc == 8'd0);
  assign p_o    = ~^fsrc;
  assign ac_o   = ac_n;
  assign cy_o   = cy_n;
  assign s_we_o = szp_we;
  assign z_we_o = szp_we;
  assign p_we_o = szp_we;
endmodule

// File: rtl/acc_alu_flags_chk.sv
`timescale 1ns/1ps
module acc_alu_flags_chk (
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [7:0] acc_o,
  input logic       acc_we_o,
  input logic       pair_we_o,
  input logic       s_o,
  input logic       z_o,
  input logic       p_o,
  input logic       cy_o,
  input logic       s_we_o,
  input logic       z_we_o,
  input logic       ac_we_o,
  input logic       p_we_o,
  input logic       cy_we_o
);
  logic rot, carry_only, no_flags;
  assign rot        = (op_i >= 5'd8) && (op_i <= 5'd11);
  assign carry_only = rot || op_i == 5'd13 || op_i == 5'd14 || op_i == 5'd16;
  assign no_flags   = !s_we_o && !z_we_o && !ac_we_o && !p_we_o;

  always_comb begin
    AST_CMP_ORDER: assert (op_i != 5'd4 || (!acc_we_o && acc_o == acc_i && cy_o == (acc_i < opnd_i) && z_o == (acc_i == opnd_i))); // R4
    AST_SZP_MATCH: assert (!(acc_we_o && s_we_o) || (s_o == acc_o[7] && z_o == (acc_o == 8'd0) && p_o == ~^acc_o)); // R5
    AST_LOGIC_CY_CLEAR: assert (!(op_i >= 5'd5 && op_i <= 5'd7) || (cy_we_o && !cy_o)); // R6
    AST_CARRY_ONLY: assert (!carry_only || (cy_we_o && no_flags)); // R9
    AST_CMA_NO_FLAG: assert (op_i != 5'd12 || (acc_o == ~acc_i && no_flags && !cy_we_o)); // R9
    AST_STC_SET: assert (op_i != 5'd14 || (cy_o && !acc_we_o)); // R10
    AST_DAD_PAIR: assert (op_i != 5'd16 || (pair_we_o && !acc_we_o)); // R12
    AST_UNDEF_IDLE: assert (op_i <= 5'd16 || (!acc_we_o && !pair_we_o && !cy_we_o && no_flags && acc_o == acc_i)); // R13
  end
endmodule

bind acc_alu_flags acc_alu_flags_chk u_chk (
  .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .acc_o(acc_o), .acc_we_o(acc_we_o),
  .pair_we_o(pair_we_o), .s_o(s_o), .z_o(z_o), .p_o(p_o), .cy_o(cy_o),
  .s_we_o(s_we_o), .z_we_o(z_we_o), .ac_we_o(ac_we_o), .p_we_o(p_we_o), .cy_we_o(cy_we_o)
);

// File: tb/tb_acc_alu_flags.sv
`timescale 1ns/1ps
module tb_acc_alu_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [4:0]  op;
  logic [7:0]  acc, opnd;
  logic        cy, ac;
  logic [15:0] pa, pb;
  logic [7:0]  acc_o;
  logic [15:0] pair_o;
  logic acc_we, pair_we, s_o, z_o, ac_o, p_o, cy_o, s_we, z_we, ac_we, p_we, cy_we;

  acc_alu_flags dut (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ac_i(ac),
    .pair_a_i(pa), .pair_b_i(pb), .acc_o(acc_o), .acc_we_o(acc_we),
    .pair_o(pair_o), .pair_we_o(pair_we), .s_o(s_o), .z_o(z_o), .ac_o(ac_o),
    .p_o(p_o), .cy_o(cy_o), .s_we_o(s_we), .z_we_o(z_we), .ac_we_o(ac_we),
    .p_we_o(p_we), .cy_we_o(cy_we)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int e_acc, e_accwe, e_pair, e_pairwe, e_szpwe, e_acwe, e_cywe;
  int e_s, e_z, e_p, e_ac, e_cy;

  function automatic string tag(int o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5, 6, 7: return "R6";
      8, 9: return "R7";
      10, 11: return "R8";
      12: return "R9";
      13, 14: return "R10";
      15: return "R11";
      16: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string what, string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d acc=%h opnd=%h cy=%0d ac=%0d: actual %h expected %h",
               req, what, op, acc, opnd, cy, ac, act, exp);
    end
  endtask

  task automatic model();
    int a = acc, b = opnd, c = cy, h = ac, fr, t, x;
    bit lo, hi, c1;
    e_acc = a; e_accwe = 0; e_pair = (pa + pb) % 65536; e_pairwe = 0;
    e_szpwe = 0; e_acwe = 0; e_cywe = 0; e_ac = h; e_cy = c; fr = a;
    case (int'(op))
      0, 1: begin
        x = (op == 1) ? c : 0;
        t = a + b + x; e_acc = t % 256; fr = e_acc; e_cy = (t > 255);
        e_ac = ((a % 16) + (b % 16) + x) > 15;
        e_accwe = 1; e_szpwe = 1; e_acwe = 1; e_cywe = 1;
      end
      2, 3, 4: begin
        x = (op == 3) ? c : 0;
        t = a - b - x; fr = (t + 256) % 256; e_cy = (t < 0);
        e_ac = ((a % 16) - (b % 16) - x) < 0;
        if (op != 4) begin e_acc = fr; e_accwe = 1; end
        e_szpwe = 1; e_acwe = 1; e_cywe = 1;
      end
      5, 6, 7: begin
        e_acc = (op == 5) ? (a & b) : (op == 6) ? (a ^ b) : (a | b);
        fr = e_acc; e_cy = 0; e_ac = (op == 5);
        e_accwe = 1; e_szpwe = 1; e_acwe = 1; e_cywe = 1;
      end
      8:  begin e_acc = ((a * 2) % 256) + a / 128; e_cy = a / 128; e_accwe = 1; e_cywe = 1; end
      9:  begin e_acc = a / 2 + (a % 2) * 128;     e_cy = a % 2;   e_accwe = 1; e_cywe = 1; end
      10: begin e_acc = ((a * 2) % 256) + c;       e_cy = a / 128; e_accwe = 1; e_cywe = 1; end
      11: begin e_acc = a / 2 + c * 128;           e_cy = a % 2;   e_accwe = 1; e_cywe = 1; end
      12: begin e_acc = 255 - a; e_accwe = 1; end
      13: begin e_cy = 1 - c; e_cywe = 1; end
      14: begin e_cy = 1; e_cywe = 1; end
      15: begin
        lo = ((a % 16) > 9) || h;
        t = a + (lo ? 6 : 0);
        e_ac = lo && ((a % 16) + 6 > 15);
        c1 = t > 255; t = t % 256;
        hi = ((t / 16) > 9) || c || c1;
        e_acc = (t + (hi ? 96 : 0)) % 256; fr = e_acc; e_cy = hi;
        e_accwe = 1; e_szpwe = 1; e_acwe = 1; e_cywe = 1;
      end
      16: begin e_pairwe = 1; e_cywe = 1; e_cy = (pa + pb) > 65535; end
      default: ;
    endcase
    e_s = fr / 128; e_z = (fr == 0);
    x = 0;
    for (int i = 0; i < 8; i++) x += (fr >> i) & 1;
    e_p = (x % 2 == 0);
  endtask

  task automatic compare();
    string r = tag(op);
    string w = (op > 16) ? "R13" : "R1";
    model();
    check("acc_o", r, acc_o, e_acc);
    check("acc_we", w, acc_we, e_accwe);
    check("pair_we", w, pair_we, e_pairwe);
    check("s_we", w, s_we, e_szpwe);
    check("z_we", w, z_we, e_szpwe);
    check("p_we", w, p_we, e_szpwe);
    check("ac_we", w, ac_we, e_acwe);
    check("cy_we", w, cy_we, e_cywe);
    if (e_szpwe != 0) begin
      check("s_o", "R5", s_o, e_s);
      check("z_o", "R5", z_o, e_z);
      check("p_o", "R5", p_o, e_p);
    end
    if (e_acwe != 0) check("ac_o", r, ac_o, e_ac);
    if (e_cywe != 0) check("cy_o", r, cy_o, e_cy);
    if (e_pairwe != 0) check("pair_o", r, pair_o, e_pair);
  endtask

  task automatic apply(int o, int a, int b, int c, int h, int x, int y);
    @(posedge clk);
    op = 5'(o); acc = 8'(a); opnd = 8'(b); cy = c[0]; ac = h[0]; pa = 16'(x); pb = 16'(y);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    op = 5'd31; acc = 8'h5A; opnd = 8'h00; cy = 1'b0; ac = 1'b0; pa = 16'h0; pb = 16'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare();                                   // R13 idle code after reset
    apply(0, 8'h1C, 8'hE4, 0, 0, 0, 0);          // R2 wrap to zero with carry
    apply(0, 8'h0F, 8'h01, 0, 0, 0, 0);          // R2 nibble carry
    apply(1, 8'hFF, 8'h00, 1, 0, 0, 0);          // R2 carry-in wraps
    apply(2, 8'h10, 8'h01, 0, 0, 0, 0);          // R3 nibble borrow
    apply(3, 8'h00, 8'hFF, 1, 0, 0, 0);          // R3 extreme borrow
    apply(4, 8'h40, 8'h41, 0, 0, 0, 0);          // R4 below
    apply(4, 8'h41, 8'h41, 0, 0, 0, 0);          // R4 equal
    apply(4, 8'h42, 8'h41, 1, 0, 0, 0);          // R4 above
    apply(5, 8'hF0, 8'h0F, 1, 0, 0, 0);          // R6 AND to zero
    apply(6, 8'hAA, 8'h55, 1, 1, 0, 0);          // R6 XOR
    apply(7, 8'h80, 8'h01, 1, 1, 0, 0);          // R6 OR
    apply(8, 8'h81, 0, 0, 0, 0, 0);              // R7
    apply(9, 8'h81, 0, 0, 0, 0, 0);              // R7
    apply(10, 8'h80, 0, 0, 0, 0, 0);             // R8
    apply(11, 8'h01, 0, 1, 0, 0, 0);             // R8
    apply(12, 8'h3C, 0, 1, 1, 0, 0);             // R9
    apply(13, 8'h11, 0, 1, 0, 0, 0);             // R10
    apply(14, 8'h11, 0, 0, 0, 0, 0);             // R10
    apply(15, 8'h9B, 0, 0, 0, 0, 0);             // R11 both nibbles corrected
    apply(15, 8'h15, 0, 0, 1, 0, 0);             // R11 forced by ac_i
    apply(15, 8'h22, 0, 1, 0, 0, 0);             // R11 forced by cy_i
    apply(15, 8'hFF, 0, 0, 0, 0, 0);             // R11 first step wraps
    apply(15, 8'h99, 0, 0, 0, 0, 0);             // R11 no correction
    apply(16, 0, 0, 0, 0, 16'hFFFF, 16'h0001);   // R12 overflow
    apply(16, 0, 0, 1, 0, 16'h1234, 16'h4321);   // R12 no overflow
    apply(20, 8'h77, 8'h11, 1, 1, 0, 0);         // R13
    for (int k = 0; k < 4000; k++)
      apply($urandom_range(31, 0), $urandom_range(255, 0), $urandom_range(255, 0),
            $urandom_range(1, 0), $urandom_range(1, 0),
            $urandom_range(65535, 0), $urandom_range(65535, 0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule